// File: doc/BRIEF.md
# Chunked Host-to-Memory Write Bridge

This block lets a byte-wide host processor fill a word-addressed external memory through a small register window. The host loads a 24-bit destination word address and a length counted in 32-bit words. It selects the host-to-memory write mode, then writes payload bytes one at a time into a single data register. The bridge packs each group of four bytes into one word, least significant byte first. Each finished word goes out on a valid/ready memory write port, and the destination address then advances by one.

The host works in chunks of 128 bytes, or fewer for the final one. Each time the memory side accepts the last word of a full chunk, a "next chunk" status flag is set. When the memory side accepts the final word of the whole transfer, a separate "complete" flag is set instead. Either flag can drive the active-high interrupt pin, subject to a mask register. The host clears a flag by writing 1 to its bit. A separate doorbell register sends a one-cycle notification pulse to an internal processor.

Back-pressure rules on the memory port:
- Once `mem_valid` rises, it stays high, with `mem_addr` and `mem_data` unchanged, until a cycle in which `mem_ready` is high.
- One finished word may wait while the next word is being packed.
- When the next word lacks only its last byte and a word is still waiting, `host_stall` is high. A data write in that state is dropped.

Top module: `chunk_xfer_bridge`

## Requirements
- R1: After reset, `mem_valid`, `irq_o`, `doorbell_o` and `host_stall` are low, and the mode (20H), address (24H-26H), count (27H-29H) and status (30H) registers read 00H.
- R2: Host register writes take effect at the clock edge that samples `host_wr`. A read strobe loads `host_rdata` at the sampling edge, and the value holds until the next read. Register offsets:
  - 20H: mode register.
  - 24H/25H/26H: destination address bits 7:0, 15:8 and 23:16.
  - 27H/28H/29H: word count bits 7:0, 15:8 and 23:16.
  - 2CH-2FH: mask registers.
  All of these read back the last value written.
- R3: Each fourth accepted write to the data register (3FH) forms one word. The first byte of the group goes to bits 7:0 and the fourth to bits 31:24. The word is issued at the current destination address. At the same edge, the address register increases by one and the count register decreases by one.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` remain unchanged on the next cycle.
- R5: `host_stall` is high while a word is waiting on the memory port and three bytes of the next word are packed. A data write made while `host_stall` is high is ignored and does not appear in any issued word.
- R6: Data-register writes are ignored when the mode register is not 02H, or when the count register is zero.
- R7: When the memory port accepts the 32nd word of a chunk and the count is not yet zero, status bit 1 is set, so status reads 02H.
- R8: When the memory port accepts the final word of the transfer, status bit 0 is set (status reads 01H) and bit 1 is not set.
- R9: Writing to 30H clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R10: `irq_o` is high exactly while a status bit is set and the matching bit of the mask register at 2CH is 1. Bit 0 enables the complete flag and bit 1 enables the next-chunk flag.
- R11: Writing 01H to 2AH drives `doorbell_o` high for exactly the one cycle after the write edge. Any other value written there gives no pulse, and 2AH reads 00H.
- R12: Any write to the mode register discards partly packed bytes and restarts the chunk word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| host_addr | input | 6 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered read data |
| host_stall | output | 1 | High when the next data byte would be dropped |
| irq_o | output | 1 | Active-high level interrupt |
| doorbell_o | output | 1 | One-cycle pulse to the internal processor |
| mem_addr | output | 24 | Word address of the issued word |
| mem_data | output | 32 | Packed little-endian word |
| mem_valid | output | 1 | Word offered to memory |
| mem_ready | input | 1 | Memory accepts the word when high with `mem_valid` |

## Verification
A wrong byte index in the packer shows up at the memory port on the next issued word, as bytes in swapped lanes or as a word issued one byte early or late. A chunk counter that is off by one sets the next-chunk flag one word early or late, so the status read and the interrupt pin are wrong within a single word of the chunk boundary. A stale count or address register shows on the first readback after the word edge, or as a transfer that accepts bytes past its end. Back-pressure faults change `mem_data` or `mem_addr` in the very cycle after a stalled offer.

// File: rtl/cxb_pkg.sv
package cxb_pkg;
  localparam int HOST_AW      = 6;
  localparam int OFS_MODE     = 'h20;
  localparam int OFS_BELL     = 'h2A;
  localparam int OFS_DEST0    = 'h24;
  localparam int OFS_LEN0     = 'h27;
  localparam int OFS_MASK0    = 'h2C;
  localparam int OFS_STAT     = 'h30;
  localparam int OFS_DATA     = 'h3F;
  localparam logic [7:0] MODE_HOST_WR = 8'h02;
  localparam logic [7:0] BELL_RING    = 8'h01;

  function automatic logic ofs_hit(input logic [HOST_AW-1:0] a, input int ofs);
    return a == HOST_AW'(ofs);
  endfunction
endpackage

// File: rtl/cxb_regs.sv
module cxb_regs
  import cxb_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 24,
  parameter int MASK_REGS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]         host_wdata,
  input  logic               host_wr,
  input  logic               host_rd,
  output logic [7:0]         host_rdata,
  input  logic               word_step,
  input  logic [7:0]         stat_byte,
  output logic [7:0]         mode,
  output logic [ADDR_W-1:0]  dest_addr,
  output logic [CNT_W-1:0]   words_left,
  output logic [7:0]         mask0,
  output logic               mode_wr,
  output logic               data_push,
  output logic               stat_wr,
  output logic               bell_pulse
);
  localparam int AB = ADDR_W / 8;
  localparam int CB = CNT_W / 8;

  logic [7:0] mask_q [MASK_REGS];
  logic [7:0] rd_mux;

  assign mode_wr   = host_wr && ofs_hit(host_addr, OFS_MODE);
  assign data_push = host_wr && ofs_hit(host_addr, OFS_DATA);
  assign stat_wr   = host_wr && ofs_hit(host_addr, OFS_STAT);
  assign mask0     = mask_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= '0;
      dest_addr  <= '0;
      words_left <= '0;
      bell_pulse <= 1'b0;
      host_rdata <= '0;
      for (int m = 0; m < MASK_REGS; m++) mask_q[m] <= '0;
    end else begin
      if (mode_wr) mode <= host_wdata;
      if (word_step) begin
        dest_addr  <= dest_addr + 1'b1;
        words_left <= words_left - 1'b1;
      end
      for (int i = 0; i < AB; i++)
        if (host_wr && ofs_hit(host_addr, OFS_DEST0 + i)) dest_addr[8*i +: 8] <= host_wdata;
      for (int i = 0; i < CB; i++)
        if (host_wr && ofs_hit(host_addr, OFS_LEN0 + i)) words_left[8*i +: 8] <= host_wdata;
      for (int m = 0; m < MASK_REGS; m++)
        if (host_wr && ofs_hit(host_addr, OFS_MASK0 + m)) mask_q[m] <= host_wdata;
      bell_pulse <= host_wr && ofs_hit(host_addr, OFS_BELL) && (host_wdata == BELL_RING);
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ofs_hit(host_addr, OFS_MODE)) rd_mux = mode;
    if (ofs_hit(host_addr, OFS_STAT)) rd_mux = stat_byte;
    for (int i = 0; i < AB; i++)
      if (ofs_hit(host_addr, OFS_DEST0 + i)) rd_mux = dest_addr[8*i +: 8];
    for (int i = 0; i < CB; i++)
      if (ofs_hit(host_addr, OFS_LEN0 + i)) rd_mux = words_left[8*i +: 8];
    for (int m = 0; m < MASK_REGS; m++)
      if (ofs_hit(host_addr, OFS_MASK0 + m)) rd_mux = mask_q[m];
  end
endmodule

// File: rtl/cxb_packer.sv
module cxb_packer #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [7:0]        push_byte,
  input  logic              enable,
  input  logic              flush,
  input  logic [ADDR_W-1:0] dest_addr,
  input  logic              mem_ready,
  output logic              word_step,
  output logic              stall,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data
);
  logic [1:0]  idx;
  logic [23:0] partial;
  logic        take;

  assign stall     = mem_valid && (idx == 2'd3);
  assign take      = push && enable && !stall;
  assign word_step = take && (idx == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      partial   <= '0;
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      if (mem_valid && mem_ready) mem_valid <= 1'b0;
      if (flush) begin
        idx <= '0;
      end else if (take) begin
        if (idx == 2'd3) begin
          mem_data  <= {push_byte, partial};
          mem_addr  <= dest_addr;
          mem_valid <= 1'b1;
          idx       <= '0;
        end else begin
          partial[8*idx +: 8] <= push_byte;
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cxb_irq.sv
module cxb_irq #(
  parameter int CHUNK_WORDS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       last,
  input  logic       restart,
  input  logic       stat_wr,
  input  logic [1:0] stat_clr,
  input  logic [1:0] mask,
  output logic [7:0] stat_byte,
  output logic       irq
);
  localparam int CW = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1;

  logic [1:0]    status;
  logic [CW-1:0] chunk_cnt;

  assign stat_byte = {6'b0, status};
  assign irq       = |(status & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= '0;
      chunk_cnt <= '0;
    end else begin
      if (stat_wr) status <= status & ~stat_clr;
      if (accept) begin
        if (last) begin
          status[0] <= 1'b1;
          chunk_cnt <= '0;
        end else if (chunk_cnt == CW'(CHUNK_WORDS - 1)) begin
          status[1] <= 1'b1;
          chunk_cnt <= '0;
        end else begin
          chunk_cnt <= chunk_cnt + 1'b1;
        end
      end
      if (restart) chunk_cnt <= '0;
    end
  end
endmodule

// File: rtl/chunk_xfer_bridge.sv
module chunk_xfer_bridge
  import cxb_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 24,
  parameter int CHUNK_BYTES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  output logic              host_stall,
  output logic              irq_o,
  output logic              doorbell_o,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              mem_valid,
  input  logic              mem_ready
);
  localparam int CHUNK_WORDS = CHUNK_BYTES / 4;

  logic [7:0]        mode;
  logic [ADDR_W-1:0] dest_addr;
  logic [CNT_W-1:0]  words_left;
  logic [7:0]        mask0;
  logic [7:0]        stat_byte;
  logic              mode_wr, data_push, stat_wr, word_step, xfer_en;

  assign xfer_en = (mode == MODE_HOST_WR) && (words_left != '0);

  cxb_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MASK_REGS(4)) regs_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .word_step(word_step), .stat_byte(stat_byte), .mode(mode),
    .dest_addr(dest_addr), .words_left(words_left), .mask0(mask0),
    .mode_wr(mode_wr), .data_push(data_push), .stat_wr(stat_wr),
    .bell_pulse(doorbell_o)
  );

  cxb_packer #(.ADDR_W(ADDR_W)) pack_i (
    .clk(clk), .rst_n(rst_n), .push(data_push), .push_byte(host_wdata),
    .enable(xfer_en), .flush(mode_wr), .dest_addr(dest_addr),
    .mem_ready(mem_ready), .word_step(word_step), .stall(host_stall),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  cxb_irq #(.CHUNK_WORDS(CHUNK_WORDS)) irq_i (
    .clk(clk), .rst_n(rst_n), .accept(mem_valid && mem_ready),
    .last(words_left == '0), .restart(mode_wr), .stat_wr(stat_wr),
    .stat_clr(host_wdata[1:0]), .mask(mask0[1:0]), .stat_byte(stat_byte),
    .irq(irq_o)
  );
endmodule

// File: rtl/cxb_checker.sv
module cxb_checker #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_stall,
  input logic              irq_o,
  input logic              doorbell_o,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic [7:0]        mode,
  input logic [CNT_W-1:0]  words_left,
  input logic [7:0]        stat_byte
);
  a_r4_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_data) && $stable(mem_addr));

  a_r5_stall_has_word: assert property (@(posedge clk) disable iff (!rst_n)
    host_stall |-> mem_valid);

  a_r6_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && mode != 8'h02) |=> !mem_valid);

  a_r6_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && words_left == '0) |=> !mem_valid);

  a_r7_chunk_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_byte[1]) |-> $past(mem_valid && mem_ready));

  a_r8_done_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_byte[0]) |-> $past(mem_valid && mem_ready));

  a_r10_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(host_wr));

  a_r11_bell_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell_o |=> !doorbell_o);
endmodule

bind chunk_xfer_bridge cxb_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_stall(host_stall),
  .irq_o(irq_o), .doorbell_o(doorbell_o), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .mode(mode), .words_left(words_left), .stat_byte(stat_byte)
);

// File: tb/chunk_xfer_bridge_tb_top.sv
module chunk_xfer_bridge_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0] a;
    logic [7:0] d;
    logic [7:0] e;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{6'h24, 8'h5A, 8'h5A}, '{6'h25, 8'hC3, 8'hC3}, '{6'h26, 8'h7E, 8'h7E},
    '{6'h27, 8'h11, 8'h11}, '{6'h28, 8'h22, 8'h22}, '{6'h29, 8'h33, 8'h33},
    '{6'h2C, 8'h03, 8'h03}, '{6'h2D, 8'hA5, 8'hA5}, '{6'h2E, 8'h0F, 8'h0F},
    '{6'h2F, 8'hF0, 8'hF0}, '{6'h2A, 8'h01, 8'h00}, '{6'h20, 8'h02, 8'h02},
    '{6'h20, 8'h00, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        host_stall, irq_o, doorbell_o, mem_valid;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [31:0] mem_data;

  int checks = 0;
  int fails  = 0;
  int n_hs   = 0;
  logic [31:0] log_data [64];
  logic [23:0] log_addr [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  chunk_xfer_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .host_stall(host_stall), .irq_o(irq_o), .doorbell_o(doorbell_o),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready)
  );

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (n_hs < 64) begin
        log_data[n_hs] <= mem_data;
        log_addr[n_hs] <= mem_addr;
      end
      n_hs <= n_hs + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic push_seq(input logic [7:0] first, input int n);
    for (int i = 0; i < n; i++) wr(6'h3F, first + 8'(i));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [31:0] held;
    int hs0;

    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 mem_valid", 32'(mem_valid), 0);
    check("R1 irq_o", 32'(irq_o), 0);
    check("R1 doorbell_o", 32'(doorbell_o), 0);
    check("R1 host_stall", 32'(host_stall), 0);
    rd(6'h20, r); check("R1 mode", 32'(r), 0);
    rd(6'h24, r); check("R1 addr", 32'(r), 0);
    rd(6'h27, r); check("R1 count", 32'(r), 0);
    rd(6'h30, r); check("R1 status", 32'(r), 0);

    // R2 register map, vector table
    for (int k = 0; k < NVEC; k++) begin
      wr(VECS[k].a, VECS[k].d);
      rd(VECS[k].a, r);
      check($sformatf("R2 reg %h", VECS[k].a), 32'(r), 32'(VECS[k].e));
    end

    // R6 mode not 02H: count is nonzero but bytes are dropped
    push_seq(8'h40, 4); idle(2);
    check("R6 mode off no word", 32'(mem_valid), 0);
    rd(6'h27, r); check("R6 mode off count kept", 32'(r), 32'h11);
    // R6 count zero
    wr(6'h27, 0); wr(6'h28, 0); wr(6'h29, 0); wr(6'h20, 8'h02);
    push_seq(8'h40, 4); idle(2);
    check("R6 zero count no word", 32'(mem_valid), 0);

    // R3 / R8 short transfer of three words
    mem_ready = 1'b1;
    wr(6'h2C, 8'h03);
    wr(6'h24, 8'h00); wr(6'h25, 8'h01); wr(6'h26, 8'h00);
    wr(6'h27, 8'h03); wr(6'h20, 8'h02);
    hs0 = n_hs;
    push_seq(8'h10, 12); idle(3);
    check("R3 word count", 32'(n_hs - hs0), 3);
    for (int k = 0; k < 3; k++) begin
      check("R3 addr", 32'(log_addr[hs0+k]), 32'h100 + 32'(k));
      check("R3 packing", log_data[hs0+k],
            {8'(8'h13 + 4*k), 8'(8'h12 + 4*k), 8'(8'h11 + 4*k), 8'(8'h10 + 4*k)});
    end
    rd(6'h24, r); check("R3 addr step", 32'(r), 32'h03);
    rd(6'h27, r); check("R3 count step", 32'(r), 0);
    rd(6'h30, r); check("R8 done status", 32'(r), 32'h01);
    check("R10 irq done", 32'(irq_o), 1);
    push_seq(8'h80, 4); idle(3);
    check("R6 past end ignored", 32'(n_hs - hs0), 3);
    wr(6'h30, 8'h02);
    rd(6'h30, r); check("R9 zero bit kept", 32'(r), 32'h01);
    wr(6'h30, 8'h01);
    rd(6'h30, r); check("R9 cleared", 32'(r), 0);
    check("R10 irq low", 32'(irq_o), 0);

    // R4 / R5 / R7 / R8 33-word transfer with back-pressure
    mem_ready = 1'b0;
    wr(6'h24, 8'h00); wr(6'h25, 8'h20); wr(6'h26, 8'h00);
    wr(6'h27, 8'h21); wr(6'h2C, 8'h01); wr(6'h20, 8'h02);
    hs0 = n_hs;
    push_seq(8'hA0, 4); idle(1);
    check("R4 valid", 32'(mem_valid), 1);
    check("R3 first data", mem_data, 32'hA3A2A1A0);
    check("R3 first addr", 32'(mem_addr), 32'h2000);
    held = mem_data;
    idle(3);
    check("R4 held valid", 32'(mem_valid), 1);
    check("R4 held data", mem_data, held);
    push_seq(8'hA4, 3);
    check("R5 stall", 32'(host_stall), 1);
    wr(6'h3F, 8'hEE);
    @(negedge clk); mem_ready = 1'b1;
    idle(2);
    check("R4 released", 32'(mem_valid), 0);
    check("R5 stall cleared", 32'(host_stall), 0);
    wr(6'h3F, 8'hA7); idle(3);
    check("R5 dropped byte", log_data[hs0+1], 32'hA7A6A5A4);
    push_seq(8'h00, 29*4); idle(3);
    rd(6'h30, r); check("R7 before boundary", 32'(r), 0);
    push_seq(8'h50, 4); idle(3);
    rd(6'h30, r); check("R7 chunk ready", 32'(r), 32'h02);
    check("R10 masked", 32'(irq_o), 0);
    wr(6'h2C, 8'h03);
    check("R10 unmasked", 32'(irq_o), 1);
    wr(6'h30, 8'h02);
    rd(6'h30, r); check("R9 chunk cleared", 32'(r), 0);
    push_seq(8'h60, 4); idle(3);
    rd(6'h30, r); check("R8 final only done", 32'(r), 32'h01);
    check("R8 total words", 32'(n_hs - hs0), 33);
    wr(6'h30, 8'h01);

    // R11 doorbell
    @(negedge clk); host_addr = 6'h2A; host_wdata = 8'h01; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    check("R11 pulse", 32'(doorbell_o), 1);
    @(negedge clk);
    check("R11 one cycle", 32'(doorbell_o), 0);
    @(negedge clk); host_addr = 6'h2A; host_wdata = 8'h05; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    check("R11 other value", 32'(doorbell_o), 0);

    // R12 mode write discards partial bytes
    wr(6'h27, 8'h02); wr(6'h20, 8'h02);
    hs0 = n_hs;
    wr(6'h3F, 8'h55); wr(6'h3F, 8'h66);
    wr(6'h20, 8'h02);
    push_seq(8'h01, 4); idle(3);
    check("R12 one word", 32'(n_hs - hs0), 1);
    check("R12 fresh packing", log_data[hs0], 32'h04030201);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule